// File: doc/BRIEF.md
# ATA Device-Side PIO Protocol Controller

This block is the device end of a parallel ATA disk. A host reaches it through single-cycle register accesses. Each access is either a byte access or a 16-bit access, and it goes either to the command block or to the control block. The block holds the task-file registers and the shadow status register, and it decodes the opcode written to the command register. It then runs the command in one of four ways:

- It completes a non-data command at once.
- It moves PIO data in or out one 512-byte sector at a time through an internal sector buffer.
- It hands a DMA command to an external engine.
- It aborts an opcode it does not support.

The interrupt request line follows the pending-interrupt state, the drive-select bit and the nIEN mask. A sector-storage back end serves sector requests. It reads and writes the shared buffer through its own word port and signals completion with a done strobe.

Top module: `ata_pio_device`

## Requirements
- R1: After reset the status register reads 0x40 (status bits: 7 busy, 6 ready, 5 fault, 4 seek, 3 data request, 0 error). The interrupt line is low.
- R2: Only command-block offset 0 (data) accepts 16-bit accesses. A 16-bit access to any other offset, and a byte access to offset 0, is ignored: a write changes nothing and a read returns 0. Offsets 1 to 7 are error, sector count, LBA low, LBA mid, LBA high, drive/head and status/command.
- R3: A byte read of the status register (offset 7) clears a pending interrupt. A read of the control block returns the same status value and has no side effect.
- R4: A command written while the selected device is idle sets busy. In the cycle after the write, data request, fault and error read 0 and the error register is cleared. Commands written to a deselected device are ignored.
- R5: The read, write and DMA commands need the LBA bit (drive/head bit 6). The 28-bit LBA is built from drive/head bits 3:0 and the three LBA bytes. A sector count of 0 means 256 sectors.
- R6: PIO data-in (0x20, 0x21):
  - A ready sector clears busy, sets data request and presents the first word at the data register.
  - If nIEN is clear it raises an interrupt, and 16-bit reads do not advance until the status register has been read.
  - Each 16-bit read advances the buffer by one word.
  - After the last word the device either fetches the next LBA (busy set, data request clear) or returns to idle with status 0x40 and no interrupt.
- R7: PIO data-out (0x30, 0x31):
  - The first sector goes to transfer with no interrupt.
  - Each full sector sets busy and seek, clears data request and is written to storage.
  - Every later sector raises an interrupt when nIEN is clear.
- R8: The non-data opcodes 0x10, 0x40, 0x41, 0x70, 0x91, 0xC6, 0xE0, 0xE7 and 0xEF complete on their own. Completion of a non-data, data-out or DMA command raises an interrupt only when nIEN (control bit 1) is clear.
- R9: An unsupported opcode, or a data command without the LBA bit, completes with the error bit set and 0x04 in the error register.
- R10: Drive/head bit 4 selects the device. Writing a value that deselects this device drops the interrupt line. Reselecting it with an interrupt still pending raises the line again.
- R11: A control write with bit 2 set forces a reset state with busy set. A later control write with bit 2 clear leaves status 0x40, clears the task file and drops any pending interrupt.
- R12: The DMA opcodes are 0xC8 (to host) and 0xCA (to disk). Either one clears busy, sets data request and raises dma_ready with the direction, LBA and sector count. A done or error strobe then sets seek, adds error bit 0 and 0x04 on error, and completes the command.
- R13: The interrupt line is high only while an interrupt is pending, the device is selected and nIEN is clear. Setting nIEN masks a pending interrupt without discarding it, and no interrupt is posted while nIEN is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hst_req | input | 1 | Host access strobe, one cycle per access |
| hst_wr | input | 1 | 1 for write, 0 for read |
| hst_ctl | input | 1 | 1 selects the control block, 0 the command block |
| hst_wide | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| hst_addr | input | 3 | Command-block register offset |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid in the access cycle |
| intrq | output | 1 | Interrupt request to the host |
| sto_req | output | 1 | Sector operation requested, held until done |
| sto_wr | output | 1 | 1 for writing the buffer to storage, 0 for filling it |
| xfer_lba | output | LBA_W | LBA of the current sector or DMA start |
| sto_we | input | 1 | Storage writes a buffer word (fill only) |
| sto_addr | input | PW | Storage word index into the buffer |
| sto_wdata | input | 16 | Storage write word |
| sto_rdata | output | 16 | Buffer word at sto_addr |
| sto_done | input | 1 | Sector operation finished |
| dma_ready | output | 1 | DMA command handed to the engine |
| dma_to_disk | output | 1 | 1 when the DMA data moves toward the disk |
| dma_nsect | output | NSW | Sectors in the DMA command (1 to 256) |
| dma_done | input | 1 | DMA engine finished without error |
| dma_err | input | 1 | DMA engine aborted |

## Verification
Some rules hold on every cycle, and the assertions check them there:
- busy and data request are never set together;
- dma_ready implies data request without busy;
- the reset state implies busy;
- a sector write-back shows busy and seek without data request;
- a status read leaves no pending interrupt;
- a masked device never posts one;
- a 16-bit write to a byte register leaves it unchanged;
- an accepted command shows busy on the next cycle.

Other behaviour shows only across whole host sequences, and the directed scenarios cover it: the order of words and LBAs across sectors, the missing interrupt on the first data-out sector, the reassertion on reselect, the 256-sector meaning of a zero count and the abort codes.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    // status bit positions
    localparam int SB_BSY  = 7;
    localparam int SB_DRDY = 6;
    localparam int SB_DF   = 5;
    localparam int SB_SEEK = 4;
    localparam int SB_DRQ  = 3;
    localparam int SB_ERR  = 0;

    localparam logic [7:0] STATUS_INIT = 8'h40;
    localparam logic [7:0] ERR_ABRT    = 8'h04;

    // command-block offsets
    localparam logic [2:0] TF_DATA  = 3'd0;
    localparam logic [2:0] TF_ERR   = 3'd1;
    localparam logic [2:0] TF_COUNT = 3'd2;
    localparam logic [2:0] TF_LBA0  = 3'd3;
    localparam logic [2:0] TF_LBA1  = 3'd4;
    localparam logic [2:0] TF_LBA2  = 3'd5;
    localparam logic [2:0] TF_DRIVE = 3'd6;
    localparam logic [2:0] TF_CMD   = 3'd7;

    localparam int DRV_LBA  = 6;
    localparam int DRV_DEV  = 4;
    localparam int CTL_SRST = 2;
    localparam int CTL_MASK = 1;

    typedef enum logic [3:0] {
        DS_IDLE, DS_SRST, DS_EXEC, DS_FETCH, DS_IN_WAIT, DS_IN_XFER,
        DS_OUT_WAIT, DS_OUT_XFER, DS_STORE, DS_DMA
    } dev_state_e;

    typedef enum logic [2:0] {
        CK_NODATA, CK_PIO_IN, CK_PIO_OUT, CK_DMA_IN, CK_DMA_OUT, CK_ABORT
    } cmd_kind_e;

endpackage

// File: rtl/ata_cmd_decode.sv
module ata_cmd_decode
    import ata_pio_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       lba_mode,
    output cmd_kind_e  kind
);

    // R5: data commands need LBA addressing; R9: everything else unknown aborts
    always_comb begin
        case (opcode)
            8'h20, 8'h21: kind = lba_mode ? CK_PIO_IN  : CK_ABORT;
            8'h30, 8'h31: kind = lba_mode ? CK_PIO_OUT : CK_ABORT;
            8'hC8:        kind = lba_mode ? CK_DMA_IN  : CK_ABORT;
            8'hCA:        kind = lba_mode ? CK_DMA_OUT : CK_ABORT;
            8'h10, 8'h40, 8'h41, 8'h70, 8'h91,
            8'hC6, 8'hE0, 8'hE7, 8'hEF: kind = CK_NODATA;  // R8
            default:      kind = CK_ABORT;
        endcase
    end

endmodule

// File: rtl/ata_sector_buf.sv
module ata_sector_buf #(
    parameter  int WORDS = 256,
    parameter  int DW    = 16,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/ata_pio_device.sv
module ata_pio_device
    import ata_pio_pkg::*;
#(
    parameter  bit DEV_ID       = 1'b0,
    parameter  int SECTOR_BYTES = 512,
    parameter  int MAX_SECT     = 256,
    parameter  int LBA_W        = 28,
    localparam int WORDS        = SECTOR_BYTES / 2,
    localparam int PW           = $clog2(WORDS),
    localparam int NSW          = $clog2(MAX_SECT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_req,
    input  logic             hst_wr,
    input  logic             hst_ctl,
    input  logic             hst_wide,
    input  logic [2:0]       hst_addr,
    input  logic [15:0]      hst_wdata,
    output logic [15:0]      hst_rdata,
    output logic             intrq,
    output logic             sto_req,
    output logic             sto_wr,
    output logic [LBA_W-1:0] xfer_lba,
    input  logic             sto_we,
    input  logic [PW-1:0]    sto_addr,
    input  logic [15:0]      sto_wdata,
    output logic [15:0]      sto_rdata,
    input  logic             sto_done,
    output logic             dma_ready,
    output logic             dma_to_disk,
    output logic [NSW-1:0]   dma_nsect,
    input  logic             dma_done,
    input  logic             dma_err
);

    typedef struct packed {
        dev_state_e       state;
        cmd_kind_e        kind;
        logic [7:0]       status;
        logic [7:0]       err;
        logic [7:0]       count;
        logic [7:0]       lba0;
        logic [7:0]       lba1;
        logic [7:0]       lba2;
        logic [7:0]       drive;
        logic             nien;
        logic             pend;
        logic [PW-1:0]    ptr;
        logic [NSW-1:0]   left;
        logic [LBA_W-1:0] lba;
    } regs_t;

    regs_t     r_q, r_d;
    cmd_kind_e dec_kind;
    logic      post_evt;
    logic [15:0] host_word;

    // host access classes
    logic acc_cmd, rd_stat, data_rd, data_wr, byte_wr, ctl_wr, sel, cmd_wr;
    assign acc_cmd = hst_req && !hst_ctl;
    assign rd_stat = acc_cmd && !hst_wr && !hst_wide && hst_addr == TF_CMD;
    assign data_rd = acc_cmd && !hst_wr && hst_wide && hst_addr == TF_DATA;
    assign data_wr = acc_cmd && hst_wr && hst_wide && hst_addr == TF_DATA;
    assign byte_wr = acc_cmd && hst_wr && !hst_wide;
    assign ctl_wr  = hst_req && hst_ctl && hst_wr && !hst_wide;
    assign sel     = r_q.drive[DRV_DEV] == DEV_ID;
    assign cmd_wr  = byte_wr && hst_addr == TF_CMD;

    ata_cmd_decode u_dec (
        .opcode   (hst_wdata[7:0]),
        .lba_mode (r_q.drive[DRV_LBA]),
        .kind     (dec_kind)
    );

    logic          buf_we;
    logic [PW-1:0] buf_waddr;
    logic [15:0]   buf_wdata;
    assign buf_we    = (r_q.state == DS_FETCH && sto_we) || (r_q.state == DS_OUT_XFER && data_wr);
    assign buf_waddr = (r_q.state == DS_FETCH) ? sto_addr  : r_q.ptr;
    assign buf_wdata = (r_q.state == DS_FETCH) ? sto_wdata : hst_wdata;

    ata_sector_buf #(.WORDS(WORDS), .DW(16)) u_buf (
        .clk     (clk),
        .we      (buf_we),
        .waddr   (buf_waddr),
        .wdata   (buf_wdata),
        .raddr_a (r_q.ptr),
        .rdata_a (host_word),
        .raddr_b (sto_addr),
        .rdata_b (sto_rdata)
    );

    always_comb begin
        logic finish;
        logic last_word;
        r_d       = r_q;
        post_evt  = 1'b0;
        finish    = 1'b0;
        last_word = r_q.ptr == PW'(WORDS - 1);

        if (byte_wr) begin
            case (hst_addr)
                TF_COUNT: r_d.count = hst_wdata[7:0];
                TF_LBA0:  r_d.lba0  = hst_wdata[7:0];
                TF_LBA1:  r_d.lba1  = hst_wdata[7:0];
                TF_LBA2:  r_d.lba2  = hst_wdata[7:0];
                TF_DRIVE: r_d.drive = hst_wdata[7:0];
                default:  ;
            endcase
        end
        if (rd_stat) r_d.pend = 1'b0;                          // R3

        case (r_q.state)
            DS_IDLE: if (cmd_wr && sel) begin                  // R4
                r_d.pend            = 1'b0;
                r_d.status[SB_BSY]  = 1'b1;
                r_d.status[SB_DRQ]  = 1'b0;
                r_d.status[SB_DF]   = 1'b0;
                r_d.status[SB_ERR]  = 1'b0;
                r_d.err             = 8'h00;
                r_d.kind            = dec_kind;
                r_d.left            = (r_q.count == 8'd0) ? NSW'(MAX_SECT) : NSW'(r_q.count);
                r_d.lba             = LBA_W'({r_q.drive[3:0], r_q.lba2, r_q.lba1, r_q.lba0});
                r_d.state           = DS_EXEC;
            end
            DS_EXEC: begin
                r_d.ptr = '0;
                case (r_q.kind)
                    CK_PIO_IN:  r_d.state = DS_FETCH;
                    CK_PIO_OUT: begin                          // R7: first sector, no interrupt
                        r_d.status[SB_BSY] = 1'b0;
                        r_d.status[SB_DRQ] = 1'b1;
                        r_d.state          = DS_OUT_XFER;
                    end
                    CK_DMA_IN, CK_DMA_OUT: begin               // R12
                        r_d.status[SB_BSY] = 1'b0;
                        r_d.status[SB_DRQ] = 1'b1;
                        r_d.state          = DS_DMA;
                    end
                    CK_ABORT: begin                            // R9
                        r_d.status[SB_ERR] = 1'b1;
                        r_d.err            = ERR_ABRT;
                        finish             = 1'b1;
                    end
                    default: finish = 1'b1;
                endcase
            end
            DS_FETCH: if (sto_done) begin                      // R6
                r_d.status[SB_BSY] = 1'b0;
                r_d.status[SB_DRQ] = 1'b1;
                post_evt           = !r_q.nien;
                r_d.state          = r_q.nien ? DS_IN_XFER : DS_IN_WAIT;
            end
            DS_IN_WAIT:  if (rd_stat) r_d.state = DS_IN_XFER;
            DS_OUT_WAIT: if (rd_stat) r_d.state = DS_OUT_XFER;
            DS_IN_XFER: if (data_rd) begin
                r_d.ptr = r_q.ptr + 1'b1;
                if (last_word) begin
                    r_d.status[SB_DRQ] = 1'b0;
                    if (r_q.left == NSW'(1)) begin
                        r_d.state = DS_IDLE;
                    end else begin
                        r_d.status[SB_BSY] = 1'b1;
                        r_d.left  = r_q.left - 1'b1;
                        r_d.lba   = r_q.lba + 1'b1;
                        r_d.state = DS_FETCH;
                    end
                end
            end
            DS_OUT_XFER: if (data_wr) begin
                r_d.ptr = r_q.ptr + 1'b1;
                if (last_word) begin
                    r_d.status[SB_BSY]  = 1'b1;
                    r_d.status[SB_SEEK] = 1'b1;
                    r_d.status[SB_DRQ]  = 1'b0;
                    r_d.state           = DS_STORE;
                end
            end
            DS_STORE: if (sto_done) begin
                if (r_q.left == NSW'(1)) begin
                    finish = 1'b1;
                end else begin
                    r_d.left           = r_q.left - 1'b1;
                    r_d.lba            = r_q.lba + 1'b1;
                    r_d.ptr            = '0;
                    r_d.status[SB_BSY] = 1'b0;
                    r_d.status[SB_DRQ] = 1'b1;
                    post_evt           = !r_q.nien;
                    r_d.state          = r_q.nien ? DS_OUT_XFER : DS_OUT_WAIT;
                end
            end
            DS_DMA: if (dma_done || dma_err) begin
                r_d.status[SB_SEEK] = 1'b1;
                if (dma_err) begin
                    r_d.status[SB_ERR] = 1'b1;
                    r_d.err            = ERR_ABRT;
                end
                finish = 1'b1;
            end
            default: ;
        endcase

        if (finish) begin                                      // R8
            r_d.status[SB_BSY] = 1'b0;
            r_d.status[SB_DRQ] = 1'b0;
            r_d.state          = DS_IDLE;
            post_evt           = !r_q.nien;
        end
        if (post_evt) r_d.pend = 1'b1;

        if (ctl_wr) begin                                      // R11, R13
            r_d.nien = hst_wdata[CTL_MASK];
            if (hst_wdata[CTL_SRST]) begin
                r_d.state          = DS_SRST;
                r_d.status[SB_BSY] = 1'b1;
                r_d.status[SB_DRQ] = 1'b0;
            end else if (r_q.state == DS_SRST) begin
                r_d.state  = DS_IDLE;
                r_d.status = STATUS_INIT;
                r_d.err    = 8'h00;
                r_d.count  = 8'h00;
                r_d.lba0   = 8'h00;
                r_d.lba1   = 8'h00;
                r_d.lba2   = 8'h00;
                r_d.drive  = 8'h00;
                r_d.pend   = 1'b0;
                r_d.ptr    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= DS_IDLE;
            r_q.kind   <= CK_NODATA;
            r_q.status <= STATUS_INIT;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: only the data register answers 16-bit accesses
    always_comb begin
        hst_rdata = '0;
        if (hst_ctl) begin
            if (!hst_wide) hst_rdata = {8'h00, r_q.status};
        end else if (hst_wide) begin
            if (hst_addr == TF_DATA) hst_rdata = host_word;
        end else begin
            case (hst_addr)
                TF_ERR:   hst_rdata = {8'h00, r_q.err};
                TF_COUNT: hst_rdata = {8'h00, r_q.count};
                TF_LBA0:  hst_rdata = {8'h00, r_q.lba0};
                TF_LBA1:  hst_rdata = {8'h00, r_q.lba1};
                TF_LBA2:  hst_rdata = {8'h00, r_q.lba2};
                TF_DRIVE: hst_rdata = {8'h00, r_q.drive};
                TF_CMD:   hst_rdata = {8'h00, r_q.status};
                default:  hst_rdata = '0;
            endcase
        end
    end

    assign intrq       = r_q.pend && sel && !r_q.nien;         // R10, R13
    assign sto_req     = r_q.state == DS_FETCH || r_q.state == DS_STORE;
    assign sto_wr      = r_q.state == DS_STORE;
    assign xfer_lba    = r_q.lba;
    assign dma_ready   = r_q.state == DS_DMA;
    assign dma_to_disk = r_q.kind == CK_DMA_OUT;
    assign dma_nsect   = r_q.left;

    // taps for the bound checker
    logic [7:0] chk_status;
    logic [7:0] chk_count;
    logic       chk_pend, chk_nien, chk_srst, chk_idle_sel;
    assign chk_status   = r_q.status;
    assign chk_count    = r_q.count;
    assign chk_pend     = r_q.pend;
    assign chk_nien     = r_q.nien;
    assign chk_srst     = r_q.state == DS_SRST;
    assign chk_idle_sel = r_q.state == DS_IDLE && sel;

endmodule

// File: rtl/ata_pio_device_chk.sv
module ata_pio_device_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hst_req,
    input logic       hst_wr,
    input logic       hst_ctl,
    input logic       hst_wide,
    input logic [2:0] hst_addr,
    input logic       sto_req,
    input logic       sto_wr,
    input logic       dma_ready,
    input logic [7:0] status,
    input logic [7:0] count,
    input logic       pend,
    input logic       nien,
    input logic       post_evt,
    input logic       in_srst,
    input logic       idle_sel
);

    logic stat_rd, wide_byte_wr, cmd_acc;
    assign stat_rd      = hst_req && !hst_wr && !hst_ctl && !hst_wide && hst_addr == 3'd7;
    assign wide_byte_wr = hst_req && hst_wr && !hst_ctl && hst_wide && hst_addr != 3'd0;
    assign cmd_acc      = hst_req && hst_wr && !hst_ctl && !hst_wide && hst_addr == 3'd7 && idle_sel;

    a_r6_bsy_drq_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[7] && status[3]));

    a_r12_dma_drq: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ready |-> (status[3] && !status[7]));

    a_r11_srst_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_srst |-> status[7]);

    a_r7_store_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (sto_req && sto_wr) |-> (status[7] && status[4] && !status[3]));

    a_r3_stat_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !post_evt) |=> !pend);

    a_r13_masked_no_post: assert property (@(posedge clk) disable iff (!rst_n)
        nien |=> !$rose(pend));

    a_r2_wide_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wide_byte_wr |=> $stable(count));

    a_r4_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_acc |=> (status[7] && !status[3] && !status[5] && !status[0]));

endmodule

bind ata_pio_device ata_pio_device_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_req   (hst_req),
    .hst_wr    (hst_wr),
    .hst_ctl   (hst_ctl),
    .hst_wide  (hst_wide),
    .hst_addr  (hst_addr),
    .sto_req   (sto_req),
    .sto_wr    (sto_wr),
    .dma_ready (dma_ready),
    .status    (chk_status),
    .count     (chk_count),
    .pend      (chk_pend),
    .nien      (chk_nien),
    .post_evt  (post_evt),
    .in_srst   (chk_srst),
    .idle_sel  (chk_idle_sel)
);

// File: tb/sim_ata_pio_device.sv
`timescale 1ns/1ps
module sim_ata_pio_device;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_req = 0, hst_wr = 0, hst_ctl = 0, hst_wide = 0;
    logic [2:0]  hst_addr = '0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic        intrq, sto_req, sto_wr, dma_ready, dma_to_disk;
    logic [27:0] xfer_lba;
    logic        sto_we = 0, sto_done = 0, dma_done = 0, dma_err = 0;
    logic [7:0]  sto_addr = '0;
    logic [15:0] sto_wdata = '0, sto_rdata;
    logic [8:0]  dma_nsect;

    int n_chk = 0, n_fail = 0;
    int wr_mism = 0, n_wr_sect = 0;
    logic [27:0] last_wr_lba = '0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    ata_pio_device u0 (.*);

    function automatic logic [15:0] pat_rd(input logic [27:0] l, input int i);
        return {l[7:0], i[7:0]} ^ 16'hA5C3;
    endfunction
    function automatic logic [15:0] pat_wr(input logic [27:0] l, input int i);
        return {i[7:0], l[7:0]} ^ 16'h3C5A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // host accesses: called at a falling edge, return at the next one
    task automatic hwr(input logic c, input logic [2:0] a, input logic w, input logic [15:0] d);
        hst_req = 1; hst_wr = 1; hst_ctl = c; hst_addr = a; hst_wide = w; hst_wdata = d;
        @(negedge clk);
        hst_req = 0; hst_wr = 0; hst_wide = 0;
    endtask
    task automatic hrd(input logic c, input logic [2:0] a, input logic w, output logic [15:0] d);
        hst_req = 1; hst_wr = 0; hst_ctl = c; hst_addr = a; hst_wide = w;
        #1 d = hst_rdata;
        @(negedge clk);
        hst_req = 0; hst_wide = 0;
    endtask
    task automatic alt(output logic [15:0] d); hrd(1, 3'd0, 0, d); endtask
    task automatic stat(output logic [15:0] d); hrd(0, 3'd7, 0, d); endtask

    task automatic wait_drq();
        logic [15:0] d;
        for (int k = 0; k < 2000; k++) begin alt(d); if (d[3]) break; end
    endtask
    task automatic wait_idle();
        logic [15:0] d;
        for (int k = 0; k < 2000; k++) begin alt(d); if (!d[7] && !d[3]) break; end
    endtask
    task automatic set_tf(input logic [7:0] cnt, input logic [7:0] lo, input logic [7:0] drv);
        hwr(0, 3'd2, 0, {8'h00, cnt});
        hwr(0, 3'd3, 0, {8'h00, lo});
        hwr(0, 3'd4, 0, 16'h0000);
        hwr(0, 3'd5, 0, 16'h0000);
        hwr(0, 3'd6, 0, {8'h00, drv});
    endtask

    // sector storage model
    initial begin
        logic [27:0] l;
        forever begin
            @(negedge clk);
            if (sto_req && rst_n) begin
                l = xfer_lba;
                if (!sto_wr) begin
                    for (int i = 0; i < 256; i++) begin
                        sto_we = 1; sto_addr = i[7:0]; sto_wdata = pat_rd(l, i);
                        @(negedge clk);
                    end
                    sto_we = 0;
                end else begin
                    for (int i = 0; i < 256; i++) begin
                        sto_addr = i[7:0];
                        #1 if (sto_rdata !== pat_wr(l, i)) wr_mism++;
                        @(negedge clk);
                    end
                    n_wr_sect++; last_wr_lba = l;
                end
                sto_done = 1;
                @(negedge clk);
                sto_done = 0;
            end
        end
    end

    task automatic t_reset();
        logic [15:0] d;
        alt(d);
        chk("R1 status", d, 16'h0040);
        chk("R1 intrq", intrq, 1'b0);
    endtask

    task automatic t_width();
        logic [15:0] d;
        hwr(0, 3'd2, 0, 16'h0005);
        hwr(0, 3'd2, 1, 16'h0077);
        hrd(0, 3'd2, 0, d);
        chk("R2 wide write ignored", d, 16'h0005);
        hrd(0, 3'd2, 1, d);
        chk("R2 wide read zero", d, 16'h0000);
    endtask

    task automatic t_nodata();
        logic [15:0] d;
        hwr(0, 3'd6, 0, 16'h00E0);
        hwr(0, 3'd7, 0, 16'h0070);
        alt(d);
        chk("R4 busy after command", {d[7], d[3], d[5], d[0]}, 4'b1000);
        alt(d);
        chk("R8 seek complete", d, 16'h0040);
        chk("R8 interrupt", intrq, 1'b1);
        alt(d);
        chk("R3 alt read keeps intrq", intrq, 1'b1);
        stat(d);
        chk("R3 status read clears", intrq, 1'b0);
    endtask

    task automatic t_nien();
        logic [15:0] d;
        hwr(1, 3'd0, 0, 16'h0002);
        hwr(0, 3'd7, 0, 16'h00E7);
        alt(d); alt(d);
        chk("R8 masked status", d, 16'h0040);
        hwr(1, 3'd0, 0, 16'h0000);
        chk("R13 no latent post", intrq, 1'b0);
        hwr(0, 3'd7, 0, 16'h00EF);
        alt(d);
        chk("R13 posted", intrq, 1'b1);
        hwr(1, 3'd0, 0, 16'h0002);
        chk("R13 masked line", intrq, 1'b0);
        hwr(1, 3'd0, 0, 16'h0000);
        chk("R13 unmask keeps pending", intrq, 1'b1);
        stat(d);
    endtask

    task automatic t_select();
        logic [15:0] d;
        hwr(0, 3'd7, 0, 16'h0070);
        alt(d);
        chk("R10 interrupt", intrq, 1'b1);
        hwr(0, 3'd6, 0, 16'h00F0);
        chk("R10 deselect drops", intrq, 1'b0);
        hwr(0, 3'd7, 0, 16'h0070);
        alt(d);
        chk("R4 deselected command ignored", d, 16'h0040);
        hwr(0, 3'd6, 0, 16'h00E0);
        chk("R10 reselect reasserts", intrq, 1'b1);
        stat(d);
        chk("R3 cleared", intrq, 1'b0);
    endtask

    task automatic t_abort();
        logic [15:0] d;
        hwr(0, 3'd6, 0, 16'h00A0);
        hwr(0, 3'd7, 0, 16'h0020);
        alt(d); alt(d);
        chk("R5 no LBA aborts", d, 16'h0041);
        hrd(0, 3'd1, 0, d);
        chk("R9 error reg", d, 16'h0004);
        stat(d);
        hwr(0, 3'd6, 0, 16'h00E0);
        hwr(0, 3'd7, 0, 16'h0099);
        alt(d); alt(d);
        chk("R9 unknown opcode", d, 16'h0041);
        stat(d);
        hwr(0, 3'd7, 0, 16'h0070);
        alt(d); alt(d);
        chk("R4 error bit cleared", d, 16'h0040);
        hrd(0, 3'd1, 0, d);
        chk("R4 error reg cleared", d, 16'h0000);
        stat(d);
    endtask

    task automatic t_pio_in();
        logic [15:0] d;
        int mism = 0;
        set_tf(8'd2, 8'h10, 8'hE0);
        hwr(0, 3'd7, 0, 16'h0020);
        for (int s = 0; s < 2; s++) begin
            wait_drq();
            chk("R6 interrupt per sector", intrq, 1'b1);
            stat(d);
            chk("R3 status read clears", intrq, 1'b0);
            for (int i = 0; i < 256; i++) begin
                hrd(0, 3'd0, 1, d);
                if (d !== pat_rd(28'h10 + 28'(s), i)) mism++;
            end
            alt(d);
            if (s == 0) chk("R6 busy between sectors", d, 16'h00C0);
            else        chk("R6 completion status", d, 16'h0040);
        end
        chk("R6 data words", mism, 0);
        chk("R6 no completion interrupt", intrq, 1'b0);
    endtask

    task automatic t_pio_out();
        logic [15:0] d;
        set_tf(8'd2, 8'h20, 8'hE0);
        hwr(0, 3'd7, 0, 16'h0030);
        for (int s = 0; s < 2; s++) begin
            wait_drq();
            if (s == 0) chk("R7 first sector no interrupt", intrq, 1'b0);
            else begin
                chk("R7 later sector interrupt", intrq, 1'b1);
                stat(d);
            end
            for (int i = 0; i < 256; i++) hwr(0, 3'd0, 1, pat_wr(28'h20 + 28'(s), i));
            alt(d);
            chk("R7 store flags", d, 16'h00D0);
        end
        wait_idle();
        alt(d);
        chk("R8 write completion status", d, 16'h0050);
        chk("R8 write completion interrupt", intrq, 1'b1);
        stat(d);
        chk("R7 stored data", wr_mism, 0);
        chk("R7 sector count", n_wr_sect, 2);
        chk("R7 last LBA", last_wr_lba, 28'h21);
    endtask

    task automatic t_dma();
        logic [15:0] d;
        set_tf(8'd0, 8'h05, 8'hE0);
        hwr(0, 3'd7, 0, 16'h00CA);
        @(negedge clk);
        chk("R12 dma ready", {dma_ready, dma_to_disk}, 2'b11);
        chk("R5 zero count is 256", dma_nsect, 9'd256);
        chk("R12 dma lba", xfer_lba, 28'h5);
        alt(d);
        chk("R12 dma status", d, 16'h0058);
        dma_done = 1; @(negedge clk); dma_done = 0;
        alt(d);
        chk("R12 dma done status", d, 16'h0050);
        chk("R12 dma interrupt", intrq, 1'b1);
        stat(d);
        set_tf(8'd1, 8'h07, 8'hE0);
        hwr(0, 3'd7, 0, 16'h00C8);
        @(negedge clk);
        chk("R12 dma to host", {dma_ready, dma_to_disk}, 2'b10);
        dma_err = 1; @(negedge clk); dma_err = 0;
        alt(d);
        chk("R12 dma error status", d, 16'h0051);
        hrd(0, 3'd1, 0, d);
        chk("R12 dma error code", d, 16'h0004);
        stat(d);
    endtask

    task automatic t_srst();
        logic [15:0] d;
        hwr(1, 3'd0, 0, 16'h0004);
        alt(d);
        chk("R11 busy in reset", d[7], 1'b1);
        hwr(1, 3'd0, 0, 16'h0000);
        alt(d);
        chk("R11 status after reset", d, 16'h0040);
        hrd(0, 3'd2, 0, d);
        chk("R11 task file cleared", d, 16'h0000);
        chk("R11 intrq low", intrq, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_width();
        t_nodata();
        t_nien();
        t_select();
        t_abort();
        t_pio_in();
        t_pio_out();
        t_dma();
        t_srst();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule